// File: doc/BRIEF.md
# Watchdog Timer with Activity Reload

This block is a system watchdog. Software programs it through a small byte-wide port with four locations: a control byte, a configuration byte, and the low and high halves of a 16-bit reload count. Once a non-zero count is written, the timer counts down by one each time unit. The time unit is either one second or one minute. The second is derived from the core clock by a parameterised divider, and a minute is sixty of those seconds.

The count can be refreshed in two ways. Software can rewrite the count bytes. Hardware can also refresh it when one of four activity pulses arrives (infrared receiver, mouse, keyboard, game port) and the matching enable bit in the control byte is set. When the count reaches zero, the block latches a sticky expiry flag and stops. If the configuration allows it, the block also drives a reset pulse of fixed length. Software can also force an immediate expiry.

Top module: `wdt_reload_timer`

## Requirements
- R1: After reset, the control byte reads 0x00, the configuration byte reads 0x80 (seconds base), the count reads 0, and `expired` and `rst_out` are low.
- R2: Address 0 reads the four source enables in bits 7:4 and the expiry flag in bit 0, with bits 3:1 reading 0. Address 1 reads back the full configuration byte as written. In that byte, bit 7 selects the base (1 = seconds, 0 = minutes), bit 6 enables the reset pulse, and bits 5:0 are held without further effect.
- R3: Address 2 writes the low byte and address 3 writes the high byte of the reload value. Either write loads the counter with the assembled 16-bit value on the next edge and restarts the prescaler. Both addresses read the live count. A value of zero leaves the timer stopped.
- R4: With the seconds base, a running count drops by one exactly TICK_DIV clocks after it was loaded and every TICK_DIV clocks after that.
- R5: With the minutes base, a running count drops by one every 60*TICK_DIV clocks.
- R6: When the count steps from 1 to 0, the expiry flag is set and the counter stays at zero.
- R7: If configuration bit 6 was set at expiry, `rst_out` is high for exactly RST_CLKS cycles starting the cycle after expiry; otherwise it stays low.
- R8: A pulse on a source whose enable is set, while the count is non-zero, reloads the last written 16-bit value on the next edge. The enable bits are 7 for infrared, 6 for mouse, 5 for keyboard and 4 for game port. A pulse on a disabled source, or any pulse while the count is zero, has no effect.
- R9: Writing the control byte with bit 1 set expires the timer at once: the count goes to 0, the flag sets, and the reset pulse follows if it is enabled. Bit 1 is not stored.
- R10: Writing exactly 0x00 to the control byte clears the expiry flag; any other control write leaves it unchanged.
- R11: Within a cycle, a forced expiry takes priority over a count write, a count write over an activity reload, and an activity reload over the final countdown step, which is then cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select (0 control, 1 config, 2 count low, 3 count high) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for `addr` |
| act_ir | input | 1 | Infrared receiver activity pulse |
| act_mouse | input | 1 | Mouse activity pulse |
| act_kbd | input | 1 | Keyboard activity pulse |
| act_game | input | 1 | Game port activity pulse |
| expired | output | 1 | Sticky expiry flag |
| rst_out | output | 1 | Reset pulse on expiry |

## Verification
The collision that matters most is an activity reload arriving on the same edge as the last countdown step. The bench watches its reference model until the count is 1 and the prescaler is at its final value, then pulses an enabled source in exactly that cycle. The expected result is that the count returns to the reload value and neither the flag nor the reset pulse appears. A second collision drives a count write together with an enabled activity pulse, and the written value must win.

// File: rtl/wdt_reload_timer.sv
module wdt_reload_timer #(
  parameter int TICK_DIV = 1000,
  parameter int RST_CLKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       act_ir,
  input  logic       act_mouse,
  input  logic       act_kbd,
  input  logic       act_game,
  output logic       expired,
  output logic       rst_out
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int RW = $clog2(RST_CLKS + 1);
  localparam int MIN_SECS = 60;

  logic [3:0]    en_q;
  logic          stat_q;
  logic [7:0]    cfg_q;
  logic [15:0]   rel_q, cnt_q;
  logic [PW-1:0] pre_q;
  logic [5:0]    min_q;
  logic [RW-1:0] rcnt_q;

  wire        ctrl_wr   = wr_en && (addr == 2'd0);
  wire        cfg_wr    = wr_en && (addr == 2'd1);
  wire        force_req = ctrl_wr && wr_data[1];
  wire        cnt_wr    = wr_en && addr[1];
  wire [15:0] rel_nx    = addr[0] ? {wr_data, rel_q[7:0]} : {rel_q[15:8], wr_data};
  wire        running   = |cnt_q;
  wire        act_hit   = running && |({act_ir, act_mouse, act_kbd, act_game} & en_q);
  wire        sec_tick  = running && (pre_q == PW'(TICK_DIV - 1));
  wire        unit_tick = sec_tick && (cfg_q[7] || (min_q == 6'(MIN_SECS - 1)));
  wire        expire_now = force_req || (!cnt_wr && !act_hit && unit_tick && (cnt_q == 16'd1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= '0;
    end else begin
      if (cnt_wr) rel_q <= rel_nx;
      if (force_req)      cnt_q <= '0;
      else if (cnt_wr)    cnt_q <= rel_nx;
      else if (act_hit)   cnt_q <= rel_q;
      else if (unit_tick) cnt_q <= cnt_q - 16'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      min_q <= '0;
    end else if (force_req || cnt_wr || act_hit || !running) begin
      pre_q <= '0;
      min_q <= '0;
    end else if (sec_tick) begin
      pre_q <= '0;
      min_q <= (min_q == 6'(MIN_SECS - 1)) ? 6'd0 : min_q + 6'd1;
    end else begin
      pre_q <= pre_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      stat_q <= 1'b0;
      cfg_q  <= 8'h80;
      rcnt_q <= '0;
    end else begin
      if (ctrl_wr) en_q <= wr_data[7:4];
      if (expire_now)                      stat_q <= 1'b1;
      else if (ctrl_wr && wr_data == 8'h00) stat_q <= 1'b0;
      if (cfg_wr) cfg_q <= wr_data;
      if (expire_now && cfg_q[6]) rcnt_q <= RW'(RST_CLKS);
      else if (rcnt_q != '0)      rcnt_q <= rcnt_q - RW'(1);
    end
  end

  assign expired = stat_q;
  assign rst_out = |rcnt_q;

  always_comb begin
    case (addr)
      2'd0:    rd_data = {en_q, 3'b000, stat_q};
      2'd1:    rd_data = cfg_q;
      2'd2:    rd_data = cnt_q[7:0];
      default: rd_data = cnt_q[15:8];
    endcase
  end

  // R3
  lo_write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2) |=> (cnt_q[7:0] == $past(wr_data)));

  // R6
  last_step_expires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_tick && cnt_q == 16'd1 && !cnt_wr && !act_hit && !force_req) |=> (cnt_q == 16'd0 && expired));

  // R7
  pulse_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> $past(cfg_q[6]));

  // R8
  activity_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_hit && !cnt_wr && !force_req) |=> (cnt_q == $past(rel_q)));

  // R9
  force_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_req |=> (expired && cnt_q == 16'd0));

  // R10
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wr_data == 8'h00 && !expire_now) |=> !expired);
endmodule

// File: tb/wdt_reload_timer_tb.sv
module wdt_reload_timer_tb;
  localparam int TD = 4;
  localparam int RC = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic act_ir = 0, act_mouse = 0, act_kbd = 0, act_game = 0;
  logic [7:0] rd_data;
  logic expired, rst_out;

  int checks = 0, fails = 0;
  bit done = 0;

  wdt_reload_timer #(.TICK_DIV(TD), .RST_CLKS(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .act_ir(act_ir), .act_mouse(act_mouse), .act_kbd(act_kbd),
    .act_game(act_game), .expired(expired), .rst_out(rst_out));

  always #5 clk = ~clk;

  // behavioural reference state
  int m_cnt, m_rel, m_pre, m_min, m_stat, m_en, m_cfg, m_rst, ocfg;
  bit exp_now, hit;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_rel = 0; m_pre = 0; m_min = 0; m_stat = 0; m_en = 0; m_cfg = 'h80; m_rst = 0;
    end else begin
      ocfg = m_cfg;
      exp_now = 0;
      hit = (m_cnt != 0) && ((int'({act_ir, act_mouse, act_kbd, act_game}) & m_en) != 0);
      if (wr_en && addr == 0 && wr_data[1]) begin
        m_cnt = 0; m_pre = 0; m_min = 0; exp_now = 1;
      end else if (wr_en && addr >= 2) begin
        if (addr == 2) m_rel = (m_rel & 'hff00) | int'(wr_data);
        else m_rel = (m_rel & 'hff) | (int'(wr_data) << 8);
        m_cnt = m_rel; m_pre = 0; m_min = 0;
      end else if (hit) begin
        m_cnt = m_rel; m_pre = 0; m_min = 0;
      end else if (m_cnt == 0) begin
        m_pre = 0; m_min = 0;
      end else if (m_pre == TD - 1) begin
        m_pre = 0;
        if (ocfg[7] || m_min == 59) begin
          m_cnt = m_cnt - 1;
          if (m_cnt == 0) exp_now = 1;
        end
        m_min = (m_min == 59) ? 0 : m_min + 1;
      end else m_pre = m_pre + 1;
      if (wr_en && addr == 0) begin
        m_en = int'(wr_data[7:4]);
        if (wr_data == 0) m_stat = 0;
      end
      if (exp_now) m_stat = 1;
      if (wr_en && addr == 1) m_cfg = int'(wr_data);
      if (exp_now && ocfg[6]) m_rst = RC;
      else if (m_rst > 0) m_rst = m_rst - 1;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model
  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      int e;
      case (addr)
        2'd0: e = (m_en << 4) | m_stat;
        2'd1: e = m_cfg;
        2'd2: e = m_cnt & 'hff;
        default: e = (m_cnt >> 8) & 'hff;
      endcase
      check((addr < 2) ? "R2 read" : "R3 count read", int'(rd_data), e);
      check("R6 flag", int'(expired), m_stat);
      check("R7 reset pulse", int'(rst_out), (m_rst != 0) ? 1 : 0);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    @(negedge clk); addr = a; #1; v = int'(rd_data);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  int v;

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(2); rst_n = 1;
    // R1
    rd(0, v); check("R1 ctrl", v, 0);
    rd(1, v); check("R1 cfg", v, 'h80);
    rd(2, v); check("R1 count", v, 0);
    check("R1 outputs", int'({expired, rst_out}), 0);

    // R2 readback, R4 seconds base, R6/R7 expiry
    wr(1, 8'h5F); rd(1, v); check("R2 cfg readback", v, 'h5F);
    wr(1, 8'hC0);
    wr(0, 8'h8E & 8'hF0 | 8'h0C & 8'h0C);
    rd(0, v); check("R2 ctrl bits 3:1 read zero", v, 'h80);
    wr(3, 8'h00); wr(2, 8'h03);
    idle(TD - 1); #1; check("R4 before tick", int'(rd_data), 3);
    idle(1); #1; check("R4 after tick", int'(rd_data), 2);
    idle(2 * TD + 2);
    check("R6 expired", int'(expired), 1);
    rd(2, v); check("R6 stopped", v, 0);
    idle(RC + 2); check("R7 pulse ended", int'(rst_out), 0);

    // R10
    wr(0, 8'h80); rd(0, v); check("R10 nonzero write keeps flag", v & 1, 1);
    wr(0, 8'h00); rd(0, v); check("R10 zero write clears flag", v & 1, 0);

    // R8 activity reloads
    wr(0, 8'hA0); wr(2, 8'h05);
    idle(3 * TD);
    @(negedge clk); act_mouse = 1; @(negedge clk); act_mouse = 0; addr = 2; #1;
    check("R8 disabled source ignored", int'(rd_data), 2);
    @(negedge clk); act_kbd = 1; @(negedge clk); act_kbd = 0; #1;
    check("R8 keyboard reload", int'(rd_data), 5);
    idle(TD); #1; check("R8 prescaler restarted", int'(rd_data), 4);

    // R11 reload meets final step
    wr(2, 8'h02);
    while (!(m_cnt == 1 && m_pre == TD - 1)) @(negedge clk);
    act_ir = 1; @(negedge clk); act_ir = 0; #1;
    check("R11 reload beats last step count", int'(rd_data), 2);
    check("R11 reload beats last step flag", int'(expired), 0);
    idle(2); check("R11 no pulse", int'(rst_out), 0);

    // R11 count write beats activity
    @(negedge clk); wr_en = 1; addr = 2; wr_data = 8'h07; act_kbd = 1;
    @(negedge clk); wr_en = 0; act_kbd = 0; #1;
    check("R11 write beats reload", int'(rd_data), 7);

    // R9 force
    wr(0, 8'hA2);
    rd(2, v); check("R9 count zero", v, 0);
    check("R9 flag", int'(expired), 1);
    rd(0, v); check("R9 force bit not stored", v, 'hA1);
    idle(RC + 2);
    wr(0, 8'h00);

    // R8 ignored when stopped
    @(negedge clk); act_ir = 1; act_kbd = 1; @(negedge clk); act_ir = 0; act_kbd = 0;
    rd(2, v); check("R8 no reload while stopped", v, 0);

    // R5 minutes base, R7 pulse disabled
    wr(1, 8'h00); wr(2, 8'h02);
    idle(60 * TD - 1); #1; check("R5 before minute", int'(rd_data), 2);
    idle(1); #1; check("R5 after minute", int'(rd_data), 1);
    idle(60 * TD + 2);
    check("R5 expired", int'(expired), 1);
    check("R7 no pulse when disabled", int'(rst_out), 0);
    wr(0, 8'h00);

    // R3 16-bit assembly and zero stop
    wr(1, 8'h80);
    wr(3, 8'h01); wr(2, 8'h00);
    rd(3, v); check("R3 high byte", v, 1);
    rd(2, v); check("R3 low byte", v, 0);
    wr(3, 8'h00);
    idle(4 * TD);
    rd(2, v); check("R3 zero stops", v, 0);
    check("R3 no expiry on zero", int'(expired), 0);

    idle(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule